// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division beside a processor pipeline. A one-cycle start strobe hands it an operation code and two operands. The unit then iterates on its own and places the 2·WIDTH-bit result into a pair of result registers. HI receives the upper product half or the remainder. LO receives the lower product half or the quotient. The pipeline keeps issuing other work while the unit runs. Only a read of HI or LO is held back, through a stall output, until the running operation has written its result.

Software can load either result register directly through a write port, for example to put back saved state after an exception handler. A direct write, or a fresh start, that arrives while an operation is running abandons that operation. The iteration core handles STEPS_PER_CYCLE result bits per clock. A generate loop builds that many chained steps, so the operation latency is WIDTH/STEPS_PER_CYCLE cycles.

Top module: `muldiv_hilo`

## Requirements
- R1: `op_i` selects the operation. Bit 1 set means divide and clear means multiply. Bit 0 set means unsigned and clear means two's-complement signed. So 00 is signed multiply, 01 unsigned multiply, 10 signed divide and 11 unsigned divide.
- R2: A multiply writes the upper WIDTH bits of the full 2·WIDTH-bit product to HI and the lower WIDTH bits to LO.
- R3: A divide with a nonzero divisor writes the quotient to LO and the remainder to HI. A signed quotient is truncated toward zero, and the remainder carries the sign of the dividend. The most negative dividend divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R4: A divide by zero completes normally with LO all ones and HI equal to the dividend, for both signed and unsigned divides.
- R5: `busy_o` rises on the cycle after a start and stays high for exactly WIDTH/STEPS_PER_CYCLE cycles. HI and LO hold the new result from the first cycle in which `busy_o` is low.
- R6: `stall_o` is high exactly when `hi_rd_i` or `lo_rd_i` is asserted while `busy_o` is high. A read while idle never stalls.
- R7: `rd_data_o` presents HI when `hi_rd_i` is high, and LO otherwise.
- R8: When idle, `hi_wr_i` or `lo_wr_i` loads `wr_data_i` into HI or LO at the next edge. The other register is left unchanged.
- R9: A direct write that arrives while busy, with no start in the same cycle, ends the operation. `busy_o` is low on the next cycle, the written register holds the written value, and the other register keeps the value it had before the operation began.
- R10: A start that arrives while busy discards the running operation. The new operation runs its full latency from the new start and writes only its own result.
- R11: After reset, HI and LO are zero and `busy_o` and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the operation selected by `op_i` |
| op_i | input | 2 | Operation code (see R1) |
| opa_i | input | WIDTH | Multiplicand or dividend |
| opb_i | input | WIDTH | Multiplier or divisor |
| hi_wr_i | input | 1 | Load HI from `wr_data_i` |
| lo_wr_i | input | 1 | Load LO from `wr_data_i` |
| wr_data_i | input | WIDTH | Value for direct writes |
| hi_rd_i | input | 1 | Read request for HI |
| lo_rd_i | input | 1 | Read request for LO |
| rd_data_o | output | WIDTH | Selected result register |
| stall_o | output | 1 | Read must wait |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the unit twice at WIDTH = 4 and drives both copies from the same stimulus. One copy uses one step per cycle and the other uses two, so both generate variants of the iteration core are exercised and the two latencies differ. The 4-bit width makes the operand space small enough to sweep completely: all four operations run over every operand pair. That sweep reaches every sign combination, every divide by zero and the most-negative-by-minus-one case, each checked against arithmetic done in the bench. Directed sequences then cover the abort by direct write, the restart by a new start, and the reset state.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      MDU_MUL_S = 2'b00,
      MDU_MUL_U = 2'b01,
      MDU_DIV_S = 2'b10,
      MDU_DIV_U = 2'b11
   } mdu_op_e;

   function automatic logic op_is_div(input mdu_op_e op);
      return op[1];
   endfunction

   function automatic logic op_is_signed(input mdu_op_e op);
      return ~op[0];
   endfunction

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
   parameter int WIDTH = 32
) (
   input  logic             signed_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   output logic [WIDTH-1:0] mag_a_o,
   output logic [WIDTH-1:0] mag_b_o,
   output logic             neg_a_o,
   output logic             neg_b_o,
   output logic             b_zero_o
);

   always_comb begin
      neg_a_o  = signed_i & opa_i[WIDTH-1];
      neg_b_o  = signed_i & opb_i[WIDTH-1];
      mag_a_o  = neg_a_o ? (~opa_i + 1'b1) : opa_i;
      mag_b_o  = neg_b_o ? (~opb_i + 1'b1) : opb_i;
      b_zero_o = (opb_i == '0);
   end

endmodule

// File: rtl/mdu_iter_core.sv
module mdu_iter_core #(
   parameter int WIDTH = 32,
   parameter int STEPS = 1
) (
   input  logic             is_div_i,
   input  logic [WIDTH-1:0] opnd_i,
   input  logic [WIDTH-1:0] up_i,
   input  logic [WIDTH-1:0] lo_i,
   output logic [WIDTH-1:0] up_o,
   output logic [WIDTH-1:0] lo_o
);

   logic [WIDTH-1:0] up_c [STEPS+1];
   logic [WIDTH-1:0] lo_c [STEPS+1];

   assign up_c[0] = up_i;
   assign lo_c[0] = lo_i;

   for (genvar s = 0; s < STEPS; s++) begin : g_step
      logic [WIDTH:0] add_s;
      logic [WIDTH:0] shl_s;
      logic [WIDTH:0] sub_s;

      always_comb begin
         // multiply: conditional add of the multiplicand, then shift right
         add_s = {1'b0, up_c[s]} + (lo_c[s][0] ? {1'b0, opnd_i} : '0);
         // divide: shift next dividend bit into the partial remainder, trial subtract
         shl_s = {up_c[s], lo_c[s][WIDTH-1]};
         sub_s = shl_s - {1'b0, opnd_i};
      end

      assign up_c[s+1] = is_div_i ? (sub_s[WIDTH] ? shl_s[WIDTH-1:0] : sub_s[WIDTH-1:0])
                                  : add_s[WIDTH:1];
      assign lo_c[s+1] = is_div_i ? {lo_c[s][WIDTH-2:0], ~sub_s[WIDTH]}
                                  : {add_s[0], lo_c[s][WIDTH-1:1]};
   end

   assign up_o = up_c[STEPS];
   assign lo_o = lo_c[STEPS];

endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix #(
   parameter int WIDTH = 32
) (
   input  logic             is_div_i,
   input  logic             prod_neg_i,
   input  logic             quo_neg_i,
   input  logic             rem_neg_i,
   input  logic [WIDTH-1:0] up_i,
   input  logic [WIDTH-1:0] lo_i,
   output logic [WIDTH-1:0] hi_o,
   output logic [WIDTH-1:0] lo_o
);

   localparam int DW = 2 * WIDTH;

   logic [DW-1:0] prod_raw;
   logic [DW-1:0] prod_fix;

   always_comb begin
      prod_raw = {up_i, lo_i};
      prod_fix = prod_neg_i ? (~prod_raw + 1'b1) : prod_raw;
      if (is_div_i) begin
         hi_o = rem_neg_i ? (~up_i + 1'b1) : up_i;
         lo_o = quo_neg_i ? (~lo_i + 1'b1) : lo_i;
      end else begin
         hi_o = prod_fix[DW-1:WIDTH];
         lo_o = prod_fix[WIDTH-1:0];
      end
   end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
   import muldiv_pkg::*;
#(
   parameter int WIDTH           = 32,
   parameter int STEPS_PER_CYCLE = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             hi_wr_i,
   input  logic             lo_wr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic             hi_rd_i,
   input  logic             lo_rd_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             stall_o,
   output logic             busy_o
);

   localparam int ITERS = WIDTH / STEPS_PER_CYCLE;
   localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("muldiv_hilo: WIDTH must be at least 2");
   end
   if (STEPS_PER_CYCLE < 1 || (WIDTH % STEPS_PER_CYCLE) != 0) begin : g_bad_steps
      $error("muldiv_hilo: STEPS_PER_CYCLE must divide WIDTH");
   end

   mdu_op_e op_e;
   assign op_e = mdu_op_e'(op_i);

   // operand conditioning
   logic [WIDTH-1:0] mag_a, mag_b;
   logic             neg_a, neg_b, b_zero;

   mdu_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .signed_i (op_is_signed(op_e)),
      .opa_i    (opa_i),
      .opb_i    (opb_i),
      .mag_a_o  (mag_a),
      .mag_b_o  (mag_b),
      .neg_a_o  (neg_a),
      .neg_b_o  (neg_b),
      .b_zero_o (b_zero)
   );

   // iteration state
   logic [WIDTH-1:0] up_q, lo_s_q, opnd_q;
   logic             is_div_q, prod_neg_q, quo_neg_q, rem_neg_q;
   logic             busy_q;
   logic [CW-1:0]    cnt_q;
   logic [WIDTH-1:0] hi_q, lo_q;

   logic [WIDTH-1:0] up_nx, lo_nx;
   logic [WIDTH-1:0] fix_hi, fix_lo;

   mdu_iter_core #(.WIDTH(WIDTH), .STEPS(STEPS_PER_CYCLE)) u_core (
      .is_div_i (is_div_q),
      .opnd_i   (opnd_q),
      .up_i     (up_q),
      .lo_i     (lo_s_q),
      .up_o     (up_nx),
      .lo_o     (lo_nx)
   );

   mdu_result_fix #(.WIDTH(WIDTH)) u_fix (
      .is_div_i   (is_div_q),
      .prod_neg_i (prod_neg_q),
      .quo_neg_i  (quo_neg_q),
      .rem_neg_i  (rem_neg_q),
      .up_i       (up_nx),
      .lo_i       (lo_nx),
      .hi_o       (fix_hi),
      .lo_o       (fix_lo)
   );

   logic any_wr, finish;
   assign any_wr = hi_wr_i | lo_wr_i;
   assign finish = busy_q & ~start_i & ~any_wr & (cnt_q == LAST);

   // control and datapath state
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q     <= 1'b0;
         cnt_q      <= '0;
         up_q       <= '0;
         lo_s_q     <= '0;
         opnd_q     <= '0;
         is_div_q   <= 1'b0;
         prod_neg_q <= 1'b0;
         quo_neg_q  <= 1'b0;
         rem_neg_q  <= 1'b0;
      end else if (start_i) begin
         busy_q     <= 1'b1;
         cnt_q      <= '0;
         up_q       <= '0;
         lo_s_q     <= mag_a;
         opnd_q     <= mag_b;
         is_div_q   <= op_is_div(op_e);
         prod_neg_q <= neg_a ^ neg_b;
         quo_neg_q  <= (neg_a ^ neg_b) & ~b_zero;
         rem_neg_q  <= neg_a;
      end else if (any_wr) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         up_q   <= up_nx;
         lo_s_q <= lo_nx;
         cnt_q  <= cnt_q + 1'b1;
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
         end
      end
   end

   // architectural result registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (hi_wr_i) begin
            hi_q <= wr_data_i;
         end else if (finish) begin
            hi_q <= fix_hi;
         end
         if (lo_wr_i) begin
            lo_q <= wr_data_i;
         end else if (finish) begin
            lo_q <= fix_lo;
         end
      end
   end

   assign busy_o    = busy_q;
   assign stall_o   = busy_q & (hi_rd_i | lo_rd_i);
   assign rd_data_o = hi_rd_i ? hi_q : lo_q;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
   parameter int WIDTH           = 32,
   parameter int STEPS_PER_CYCLE = 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             hi_wr_i,
   input logic             lo_wr_i,
   input logic [WIDTH-1:0] wr_data_i,
   input logic             busy_o,
   input logic             stall_o,
   input logic [WIDTH-1:0] hi_q,
   input logic [WIDTH-1:0] lo_q
);

   localparam int ITERS = WIDTH / STEPS_PER_CYCLE;
   localparam int RW    = $clog2(ITERS + 2);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (start_i) begin
         run_q <= '0;
      end else if (busy_o) begin
         run_q <= run_q + 1'b1;
      end
   end

   AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(busy_o) && !$past(hi_wr_i) && !$past(lo_wr_i)) |-> (run_q == RW'(ITERS))); // R5

   AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o); // R10

   AST_WRITE_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((hi_wr_i || lo_wr_i) && !start_i) |=> !busy_o); // R9

   AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !stall_o); // R6

   AST_HI_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !hi_wr_i) |=> (!busy_o || $stable(hi_q))); // R5

   AST_LO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !lo_wr_i) |=> (!busy_o || $stable(lo_q))); // R5

   AST_DIRECT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_wr_i |=> (hi_q == $past(wr_data_i))); // R8

   AST_DIRECT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_wr_i |=> (lo_q == $past(wr_data_i))); // R8

endmodule

bind muldiv_hilo mdu_checker #(
   .WIDTH           (WIDTH),
   .STEPS_PER_CYCLE (STEPS_PER_CYCLE)
) u_mdu_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .start_i   (start_i),
   .hi_wr_i   (hi_wr_i),
   .lo_wr_i   (lo_wr_i),
   .wr_data_i (wr_data_i),
   .busy_o    (busy_o),
   .stall_o   (stall_o),
   .hi_q      (hi_q),
   .lo_q      (lo_q)
);

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int MASK       = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [1:0]   op;
   logic [W-1:0] opa, opb, wdata;
   logic         hi_wr, lo_wr, hi_rd, lo_rd;
   logic [W-1:0] rd1, rd2;
   logic         stall1, stall2, busy1, busy2;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   muldiv_hilo #(.WIDTH(W), .STEPS_PER_CYCLE(1)) dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
      .opa_i(opa), .opb_i(opb), .hi_wr_i(hi_wr), .lo_wr_i(lo_wr),
      .wr_data_i(wdata), .hi_rd_i(hi_rd), .lo_rd_i(lo_rd),
      .rd_data_o(rd1), .stall_o(stall1), .busy_o(busy1)
   );

   muldiv_hilo #(.WIDTH(W), .STEPS_PER_CYCLE(2)) dut_fast (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
      .opa_i(opa), .opb_i(opb), .hi_wr_i(hi_wr), .lo_wr_i(lo_wr),
      .wr_data_i(wdata), .hi_rd_i(hi_rd), .lo_rd_i(lo_rd),
      .rd_data_o(rd2), .stall_o(stall2), .busy_o(busy2)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic int sx(input int v);
      return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
   endfunction

   // R1 encoding: 0 mul signed, 1 mul unsigned, 2 div signed, 3 div unsigned
   task automatic model(input int o, input int a, input int b, output int ehi, output int elo);
      int p, q, r;
      case (o)
         0: begin p = sx(a) * sx(b); ehi = (p >>> W) & MASK; elo = p & MASK; end
         1: begin p = a * b;         ehi = (p >>> W) & MASK; elo = p & MASK; end
         default: begin
            if (b == 0) begin
               elo = MASK; ehi = a;
            end else if (o == 2) begin
               q = sx(a) / sx(b); r = sx(a) % sx(b);
               elo = q & MASK; ehi = r & MASK;
            end else begin
               elo = a / b; ehi = a % b;
            end
         end
      endcase
   endtask

   // drive at a falling edge; returns at the following falling edge with start low
   task automatic launch(input int o, input int a, input int b);
      start = 1'b1; op = 2'(o); opa = W'(a); opb = W'(b);
      @(negedge clk);
      start = 1'b0;
   endtask

   // count busy cycles of each copy, checking the read interlock with hi_rd held (R6)
   task automatic wait_done(output int c1, output int c2);
      c1 = 0; c2 = 0;
      hi_rd = 1'b1; lo_rd = 1'b0;
      for (int i = 0; i < 12; i++) begin
         #1;
         if (busy1) c1++;
         if (busy2) c2++;
         if (stall1 != busy1) check("R6", "stall during read (1 step)", stall1, busy1);
         if (stall2 != busy2) check("R6", "stall during read (2 steps)", stall2, busy2);
         if (!busy1 && !busy2) break;
         @(negedge clk);
      end
      hi_rd = 1'b0;
   endtask

   task automatic read_both(output int h1, output int l1, output int h2, output int l2);
      hi_rd = 1'b1; lo_rd = 1'b0; #1;
      h1 = int'(rd1); h2 = int'(rd2);
      hi_rd = 1'b0; lo_rd = 1'b1; #1;
      l1 = int'(rd1); l2 = int'(rd2);
      lo_rd = 1'b0;
   endtask

   initial begin
      int ehi, elo, c1, c2, h1, l1, h2, l2;
      string tag;
      rst_n = 1'b0; start = 1'b0; op = '0; opa = '0; opb = '0; wdata = '0;
      hi_wr = 1'b0; lo_wr = 1'b0; hi_rd = 1'b0; lo_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      read_both(h1, l1, h2, l2);
      check("R11", "HI after reset", h1, 0);
      check("R11", "LO after reset", l1, 0);
      check("R11", "busy after reset", int'(busy1) + int'(busy2), 0);
      hi_rd = 1'b1; #1;
      check("R6", "idle read stall", int'(stall1) + int'(stall2), 0);
      hi_rd = 1'b0;

      // R8 idle direct writes
      hi_wr = 1'b1; wdata = W'(6);
      @(negedge clk);
      hi_wr = 1'b0;
      read_both(h1, l1, h2, l2);
      check("R8", "HI after write", h1, 6);
      check("R8", "LO untouched by HI write", l1, 0);
      check("R8", "HI after write (2 steps)", h2, 6);
      lo_wr = 1'b1; wdata = W'(2);
      @(negedge clk);
      lo_wr = 1'b0;
      read_both(h1, l1, h2, l2);
      check("R8", "LO after write", l1, 2);
      check("R8", "HI untouched by LO write", h1, 6);
      check("R7", "read selects LO (2 steps)", l2, 2);

      // R9 abort by a direct write one cycle into a multiply
      launch(1, 7, 7);
      lo_wr = 1'b1; wdata = W'(9);
      @(negedge clk);
      lo_wr = 1'b0;
      #1;
      check("R9", "busy after abort", int'(busy1) + int'(busy2), 0);
      read_both(h1, l1, h2, l2);
      check("R9", "written LO", l1, 9);
      check("R9", "HI keeps prior value", h1, 6);
      check("R9", "HI keeps prior value (2 steps)", h2, 6);
      repeat (6) @(negedge clk);
      read_both(h1, l1, h2, l2);
      check("R9", "abandoned result never lands", h1 * 16 + l1, 6 * 16 + 9);

      // R10 restart: divide interrupted by an unsigned multiply 15*15 = 225
      launch(3, 13, 3);
      launch(1, 15, 15);
      wait_done(c1, c2);
      check("R10", "latency after restart (1 step)", c1, W);
      check("R10", "latency after restart (2 steps)", c2, W / 2);
      read_both(h1, l1, h2, l2);
      check("R10", "HI of new op", h1, 14);
      check("R10", "LO of new op", l1, 1);
      check("R10", "LO of new op (2 steps)", l2, 1);

      // R1..R5 exhaustive sweep over all operations and operand pairs
      for (int o = 0; o < 4; o++) begin
         for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
               model(o, a, b, ehi, elo);
               if (o < 2)       tag = "R2";
               else if (b == 0) tag = "R4";
               else             tag = "R3";
               launch(o, a, b);
               wait_done(c1, c2);
               check("R5", "latency (1 step)", c1, W);
               check("R5", "latency (2 steps)", c2, W / 2);
               read_both(h1, l1, h2, l2);
               check(tag, $sformatf("R1 op %0d a %0d b %0d HI", o, a, b), h1, ehi);
               check(tag, $sformatf("R1 op %0d a %0d b %0d LO", o, a, b), l1, elo);
               check(tag, $sformatf("R1 op %0d a %0d b %0d HI (2 steps)", o, a, b), h2, ehi);
               check(tag, $sformatf("R1 op %0d a %0d b %0d LO (2 steps)", o, a, b), l2, elo);
               @(negedge clk);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule